// File: doc/BRIEF.md
# Video Line Capture Unit

This block sits on a parallel video stream clocked by the pixel clock: a 24-bit RGB word plus horizontal and vertical sync. When armed, it counts lines from the vertical sync and finds the programmed line. It then stores the pixels of that line into an on-chip buffer of 2048 entries. It can keep every pixel, or only one pixel out of every N, with N from 1 to 16. Taking fewer samples speeds up a measurement at the cost of horizontal resolution.

Each arm yields one line. A host builds a whole still image by arming again and again with different target lines. When a capture ends, a done flag rises and stays up. The host then reads the stored words by address through a read port with one cycle of latency. Each sync input has its own polarity setting, so the block accepts both active-high and active-low timing. The block is written for pixel clocks of up to 58 MHz.

Top module: `vline_capture`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `busy` are 0 and stay 0 until a start pulse arrives.
- R2: A `start` pulse while the unit is idle or done sets `busy` on the next cycle and clears `done`. It also latches the target line, width and step; later changes on the configuration inputs have no effect until the next accepted arm.
- R3: `cfg_hs_pol`/`cfg_vs_pol` = 1 means that sync is active-high and 0 means active-low. Only a transition from inactive to active level counts as a sync edge.
- R4: An active VSYNC edge resets the line count to 0, and each active HSYNC edge increments it, so line 1 is the first line after VSYNC. The unit captures the next line whose number equals the target (1 to 2047), and the count saturates at 2047.
- R5: Pixel 0 of the captured line is the word present on the first clock after the target line's HSYNC edge. The word present at the edge itself is never stored. Pixel 0 goes to address 0.
- R6: `cfg_step_m1` holds N-1, where N is 1 to 16. Only pixel indices 0, N, 2N, … are stored, at consecutive addresses starting from 0.
- R7: Capture stops after `cfg_width` pixels (1 to 2047), having written exactly ceil(width/N) entries. Entries at higher addresses keep their earlier contents.
- R8: An HSYNC edge that arrives before the width is reached ends the capture, and the pixel on that edge cycle is not stored. An early VSYNC edge ends the capture in the same way.
- R9: `done` rises, and `busy` falls, on the clock edge of the final write or of the terminating sync edge. `done` then stays high until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored. The capture in progress keeps its latched configuration and its data.
- R11: `rd_data` shows the buffer entry at the `rd_addr` value sampled on the previous clock edge. Each word is stored unchanged, with red in bits 23:16, green in 15:8 and blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line | input | 11 | Target line number, 1 to 2047 |
| cfg_width | input | 11 | Pixels to examine, 1 to 2047 |
| cfg_step_m1 | input | 4 | Decimation step minus one |
| cfg_hs_pol | input | 1 | 1: HSYNC active-high, 0: active-low |
| cfg_vs_pol | input | 1 | 1: VSYNC active-high, 0: active-low |
| start | input | 1 | Arm pulse, one clock wide |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_rgb | input | 24 | Pixel word, R:G:B |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | Capture finished, holds until re-arm |
| rd_addr | input | 11 | Buffer read address |
| rd_data | output | 24 | Buffer word, one cycle after address |

## Verification
Some rules are checked by the assertions on every cycle:
- `done` and `busy` are never high together.
- `done` holds until a start arrives.
- `busy` only rises after a start.
- Buffer writes happen only while busy, never on a sync edge cycle, and at addresses that step by one.
- The line count is zero after every VSYNC edge.

Other behaviour can only be shown by the bench's scenarios, because each depends on a whole frame of stimulus compared against expected pixel words:
- that the right line is chosen, including line 2047;
- that pixel 0 is taken one clock after the edge;
- the decimation pattern and the width limit at 2047;
- the early-HSYNC cut-off;
- active-low sync handling;
- that re-arming during a capture is ignored.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int PIX_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/vlc_rst_sync.sv
module vlc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/vlc_sync_edge.sv
// Active-edge detection for a set of sync lines with per-line polarity.
module vlc_sync_edge #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] raw,
  input  logic [NUM-1:0] pol,
  output logic [NUM-1:0] edge_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_line
    logic act;
    logic prev_q;

    assign act = pol[i] ? raw[i] : ~raw[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= act;
    end

    assign edge_o[i] = act & ~prev_q;
  end
endmodule

// File: rtl/vlc_line_ctr.sv
// Line counter: cleared by vertical edge, advanced by horizontal edge.
module vlc_line_ctr #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_edge,
  input  logic             vs_edge,
  output logic [CNT_W-1:0] line_cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (vs_edge) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (hs_edge && (cnt_q != '1)) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign line_cnt = cnt_q;
endmodule

// File: rtl/vlc_capture_fsm.sv
// Arm / wait-for-line / capture / done sequencer with decimation.
module vlc_capture_fsm
  import vlc_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int STEP_W = 4,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_line,
  input  logic [CNT_W-1:0]  cfg_width,
  input  logic [STEP_W-1:0] cfg_step_m1,
  input  logic              hs_edge,
  input  logic              vs_edge,
  input  logic [CNT_W-1:0]  line_cnt,
  input  logic [DATA_W-1:0] pix_in,
  output logic              wr_en,
  output logic [CNT_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  cap_state_e        state_q, state_d;
  logic [CNT_W-1:0]  line_q;
  logic [CNT_W-1:0]  width_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  pix_q, pix_d;
  logic [STEP_W-1:0] phase_q, phase_d;
  logic [CNT_W-1:0]  addr_q, addr_d;

  logic [CNT_W:0]    next_line;
  logic              arm;
  logic              hit;
  logic              edge_any;
  logic              cnt_clr;
  logic              cnt_adv;
  logic              keep;
  logic              last_pix;

  assign next_line = {1'b0, line_cnt} + (CNT_W + 1)'(1);
  assign arm       = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign hit       = hs_edge && !vs_edge && (next_line == {1'b0, line_q});
  assign edge_any  = hs_edge || vs_edge;
  assign cnt_clr   = (state_q == ST_ARMED) && hit;
  assign cnt_adv   = (state_q == ST_CAPT) && !edge_any;
  assign keep      = (phase_q == '0);
  assign last_pix  = (pix_q == (width_q - CNT_W'(1)));

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (arm) state_d = ST_ARMED;
      ST_ARMED:         if (hit) state_d = ST_CAPT;
      ST_CAPT: begin
        if (edge_any)      state_d = ST_DONE;
        else if (last_pix) state_d = ST_DONE;
      end
      default:          state_d = ST_IDLE;
    endcase
  end

  // counter next values
  always_comb begin
    if (cnt_clr) begin
      pix_d   = '0;
      phase_d = '0;
      addr_d  = '0;
    end else begin
      pix_d   = pix_q + CNT_W'(1);
      phase_d = (phase_q == step_q) ? '0 : phase_q + STEP_W'(1);
      addr_d  = keep ? addr_q + CNT_W'(1) : addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      width_q <= '0;
      step_q  <= '0;
      pix_q   <= '0;
      phase_q <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (arm) begin
        line_q  <= cfg_line;
        width_q <= cfg_width;
        step_q  <= cfg_step_m1;
      end
      if (cnt_clr || cnt_adv) begin
        pix_q   <= pix_d;
        phase_q <= phase_d;
        addr_q  <= addr_d;
      end
    end
  end

  assign wr_en   = cnt_adv && keep;
  assign wr_addr = addr_q;
  assign wr_data = pix_in;
  assign busy    = (state_q == ST_ARMED) || (state_q == ST_CAPT);
  assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/vlc_linebuf.sv
// Single write port, registered read port line store.
module vlc_linebuf #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/vline_capture.sv
module vline_capture #(
  parameter int CNT_W  = 11,
  parameter int STEP_W = 4,
  parameter int PIX_W  = vlc_pkg::PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_line,
  input  logic [CNT_W-1:0]  cfg_width,
  input  logic [STEP_W-1:0] cfg_step_m1,
  input  logic              cfg_hs_pol,
  input  logic              cfg_vs_pol,
  input  logic              start,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic [PIX_W-1:0]  pix_rgb,
  output logic              busy,
  output logic              done,
  input  logic [CNT_W-1:0]  rd_addr,
  output logic [PIX_W-1:0]  rd_data
);
  logic             rst_sync_n;
  logic [1:0]       sync_edges;
  logic             hs_edge;
  logic             vs_edge;
  logic [CNT_W-1:0] line_cnt;
  logic             wr_en;
  logic [CNT_W-1:0] wr_addr;
  logic [PIX_W-1:0] wr_data;

  vlc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  vlc_sync_edge #(.NUM(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .raw    ({pix_vs, pix_hs}),
    .pol    ({cfg_vs_pol, cfg_hs_pol}),
    .edge_o (sync_edges)
  );

  assign hs_edge = sync_edges[0];
  assign vs_edge = sync_edges[1];

  vlc_line_ctr #(.CNT_W(CNT_W)) u_lines (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hs_edge  (hs_edge),
    .vs_edge  (vs_edge),
    .line_cnt (line_cnt)
  );

  vlc_capture_fsm #(.CNT_W(CNT_W), .STEP_W(STEP_W), .DATA_W(PIX_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .cfg_line    (cfg_line),
    .cfg_width   (cfg_width),
    .cfg_step_m1 (cfg_step_m1),
    .hs_edge     (hs_edge),
    .vs_edge     (vs_edge),
    .line_cnt    (line_cnt),
    .pix_in      (pix_rgb),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy        (busy),
    .done        (done)
  );

  vlc_linebuf #(.ADDR_W(CNT_W), .DATA_W(PIX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/vlc_checker.sv
module vlc_checker #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             hs_edge,
  input logic             vs_edge,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_addr,
  input logic [CNT_W-1:0] line_cnt
);
  p_done_excl_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_arm_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (busy && !done));

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_write_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  p_no_write_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge || vs_edge) |-> !wr_en);

  p_addr_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_addr == $past(wr_addr) + CNT_W'(1)));

  p_line_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> (line_cnt == '0));
endmodule

bind vline_capture vlc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .hs_edge  (hs_edge),
  .vs_edge  (vs_edge),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .line_cnt (line_cnt)
);

// File: tb/vline_capture_tb_top.sv
`timescale 1ns/1ps
module vline_capture_tb_top;
  logic        clk;
  logic        rst_n;
  logic [10:0] cfg_line;
  logic [10:0] cfg_width;
  logic [3:0]  cfg_step_m1;
  logic        cfg_hs_pol;
  logic        cfg_vs_pol;
  logic        start;
  logic        pix_hs;
  logic        pix_vs;
  logic [23:0] pix_rgb;
  logic        busy;
  logic        done;
  logic [10:0] rd_addr;
  logic [23:0] rd_data;

  int checks;
  int failures;
  logic [23:0] exp_q[$];

  vline_capture dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_line(cfg_line), .cfg_width(cfg_width),
    .cfg_step_m1(cfg_step_m1), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
    .start(start), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_rgb(pix_rgb),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [23:0] pat(int ln, int k);
    logic [31:0] l;
    logic [31:0] p;
    l = ln;
    p = k;
    return {l[4:0], p[10:0], p[7:0] ^ 8'hC3};
  endfunction

  task automatic check_eq(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_sync(bit hs_act, bit vs_act, logic [23:0] rgb);
    @(negedge clk);
    pix_hs  = cfg_hs_pol ? hs_act : !hs_act;
    pix_vs  = cfg_vs_pol ? vs_act : !vs_act;
    pix_rgb = rgb;
  endtask

  // One frame: VSYNC pulse, nlines lines of period per, then a closing HSYNC edge.
  task automatic drive_frame(int nlines, int per);
    repeat (2) drive_sync(0, 0, 24'h0);
    repeat (2) drive_sync(0, 1, 24'h0);
    repeat (2) drive_sync(0, 0, 24'h0);
    for (int ln = 1; ln <= nlines; ln++) begin
      for (int c = 0; c < per; c++) begin
        drive_sync(c < 2, 0, (c == 0) ? 24'hFFFFFF : pat(ln, c - 1));
      end
    end
    repeat (2) drive_sync(1, 0, 24'h0);
    repeat (2) drive_sync(0, 0, 24'h0);
  endtask

  task automatic set_cfg(int ln, int w, int n, bit hp, bit vp);
    @(negedge clk);
    cfg_line    = 11'(ln);
    cfg_width   = 11'(w);
    cfg_step_m1 = 4'(n - 1);
    cfg_hs_pol  = hp;
    cfg_vs_pol  = vp;
    pix_hs      = !hp;
    pix_vs      = !vp;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic arm();
    pulse_start();
    check_eq("R2 busy after arm", 24'(busy), 24'd1);
    check_eq("R2 done cleared by arm", 24'(done), 24'd0);
  endtask

  // driver side of the scoreboard
  task automatic push_expected(int ln, int w, int n, int per);
    int lim;
    lim = (w < per - 1) ? w : per - 1;
    for (int k = 0; k < lim; k += n) exp_q.push_back(pat(ln, k));
  endtask

  task automatic read_at(int a, output logic [23:0] v);
    @(negedge clk);
    rd_addr = 11'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  // monitor side: read the buffer in address order and pop expectations
  task automatic drain(string req);
    int a;
    logic [23:0] v;
    logic [23:0] e;
    a = 0;
    while (exp_q.size() > 0) begin
      read_at(a, v);
      e = exp_q.pop_front();
      check_eq(req, v, e);
      a++;
    end
  endtask

  task automatic finish_check();
    repeat (2) @(negedge clk);
    check_eq("R9 done after capture", 24'(done), 24'd1);
    check_eq("R9 busy low after capture", 24'(busy), 24'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] v;
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    start = 1'b0;
    rd_addr = '0;
    pix_rgb = '0;
    cfg_line = 11'd1;
    cfg_width = 11'd1;
    cfg_step_m1 = '0;
    cfg_hs_pol = 1'b1;
    cfg_vs_pol = 1'b1;
    pix_hs = 1'b0;
    pix_vs = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R1 done in reset", 24'(done), 24'd0);
    check_eq("R1 busy in reset", 24'(busy), 24'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_eq("R1 idle after reset", 24'({busy, done}), 24'd0);

    // R4 R5 R11: line 3, full step, width limit
    set_cfg(3, 12, 1, 1, 1);
    arm();
    push_expected(3, 12, 1, 20);
    drive_frame(5, 20);
    finish_check();
    drain("R5 R4 R11 line3 pixels");

    // R6: step 4, width 13 -> k = 0,4,8,12
    set_cfg(1, 13, 4, 1, 1);
    arm();
    push_expected(1, 13, 4, 20);
    drive_frame(3, 20);
    finish_check();
    drain("R6 decimated pixels");
    read_at(4, v);
    check_eq("R7 entry above count kept", v, pat(3, 4));

    // R8: width 50 but line period leaves 15 pixels
    set_cfg(2, 50, 1, 1, 1);
    arm();
    push_expected(2, 50, 1, 16);
    drive_frame(4, 16);
    finish_check();
    drain("R8 early HSYNC cut");

    // R3: active-low syncs, step 2, width 6
    set_cfg(4, 6, 2, 0, 0);
    repeat (3) @(negedge clk);
    arm();
    push_expected(4, 6, 2, 20);
    drive_frame(5, 20);
    finish_check();
    drain("R3 active-low capture");
    read_at(3, v);
    check_eq("R7 untouched entry 3", v, pat(2, 3));
    read_at(14, v);
    check_eq("R7 untouched entry 14", v, pat(2, 14));

    // R10: re-arm while armed and while capturing is ignored
    set_cfg(2, 8, 1, 1, 1);
    arm();
    @(negedge clk);
    cfg_line = 11'd4;
    cfg_width = 11'd3;
    pulse_start();
    check_eq("R10 still busy after ignored start", 24'(busy), 24'd1);
    push_expected(2, 8, 1, 20);
    fork
      drive_frame(4, 20);
      begin
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    finish_check();
    drain("R10 latched config used");
    repeat (10) @(negedge clk);
    check_eq("R9 done holds", 24'(done), 24'd1);

    // R4 boundary: line 2047
    set_cfg(2047, 2047, 1, 1, 1);
    arm();
    push_expected(2047, 2047, 1, 12);
    drive_frame(2047, 12);
    finish_check();
    drain("R4 line 2047");

    // R7 boundary: width 2047 with step 16 -> 128 entries
    set_cfg(1, 2047, 16, 1, 1);
    arm();
    push_expected(1, 2047, 16, 2049);
    drive_frame(1, 2049);
    finish_check();
    drain("R7 R6 full width step16");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule